// File: doc/BRIEF.md
# Reed-Solomon Symbol-to-Byte Error Corrector

This block sits behind a Reed-Solomon decoder that works on 12-bit symbols and repairs a flash page held in two byte-wide buffers: a data area of `DATA_BYTES` bytes and a spare area of `SPARE_BYTES` bytes behind it. The decoder hands over a short list of error entries. Each entry carries a symbol position and a 12-bit error pattern, and the list ends with a last flag. Symbols are packed three bytes to every two symbols. An odd symbol starts on a byte boundary. An even symbol starts four bits into a byte. The symbol at position `(2*DATA_BYTES)/3` (1365 by default) is split: its first byte is the last data byte and its second byte is the first spare byte.

For each accepted entry the block works out which one or two bytes it touches and the XOR mask for each. It then runs one read-modify-write per byte on a byte port. This port has a one-cycle read latency: read data is valid in the cycle after `mem_rd`, and the write goes out in that same cycle. When the last entry has been handled, `done` pulses for one cycle with the result. On success the result is the number of entries applied. On failure it is an uncorrectable flag with a count of zero.

The entry input is valid/ready. `in_ready` is high only while the block is idle. An entry is taken on a clock edge where `in_valid` and `in_ready` are both high. After that `in_ready` stays low until the entry's byte updates are finished, and also through the `done` cycle for a last entry. A producer may hold `in_valid` high while it waits, and may insert idle cycles between entries. The fields of an entry must stay stable until it is taken.

Top module: `rs_byte_fixer`

## Requirements
- R1: An odd position p whose bytes fall in the data area XORs byte floor(3p/2) with pattern bits 11..4, and byte floor(3p/2)+1 with pattern bits 3..0 placed in byte bits 7..4 (low nibble zero).
- R2: An even position p > 0 in the data area XORs byte floor(3p/2)-1 with pattern bits 11..8 placed in byte bits 3..0 (upper nibble zero), and byte floor(3p/2) with pattern bits 7..0.
- R3: Position 0 XORs only data byte 0, with pattern bits 7..0. If any of pattern bits 11..8 is set, the entry fails and nothing is written.
- R4: Bytes are numbered across the data area and then the spare area, so a byte index i ≥ DATA_BYTES is spare byte i-DATA_BYTES. Position 1365 therefore updates data byte 2047 and spare byte 0, and positions 1366..1374 follow the R1/R2 rules inside the spare area.
- R5: A position above LAST_POS (1374), or one whose bytes would fall beyond the spare area, fails and writes nothing.
- R6: The entry that would be number MAX_ERR+1 (the fifth by default) in a list fails and writes nothing. Up to MAX_ERR entries succeed.
- R7: After a failure, the rest of the list is still accepted but writes nothing. `done` then reports `done_fail`=1 and `done_count`=0. Entries before the failure keep their updates.
- R8: In the cycle after the final byte update of the last entry (or after its check, if that entry wrote nothing), `done` is high for exactly one cycle. On success `done_fail`=0 and `done_count` equals the number of entries. Outside `done` both status outputs are zero.
- R9: Each byte update is `mem_rd` for one cycle, then `mem_wr` in the next cycle with the same area and address and `mem_wdata` = read data XOR mask. `in_ready` is low from acceptance until the entry is finished: 1 check cycle + 2 cycles per byte, plus 1 cycle for the done pulse on a last entry.
- R10: After reset `in_ready` is 1, and `done`, `mem_rd` and `mem_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Error entry valid |
| in_ready | output | 1 | Block can take an entry |
| in_pos | input | POS_W | Symbol position |
| in_pat | input | 12 | Error pattern |
| in_last | input | 1 | Final entry of the list |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_spare | output | 1 | 1 selects the spare area, 0 the data area |
| mem_addr | output | ADDR_W | Byte address inside the selected area |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Byte read data, valid in the cycle after mem_rd |
| done | output | 1 | One-cycle result pulse |
| done_fail | output | 1 | Page uncorrectable |
| done_count | output | CNT_W | Entries applied on success |

## Verification
The bench builds the block with its default parameters. These are a 2048-byte data area, a 64-byte spare area, four correctable entries and a last position of 1374, so the real split symbol and the spare-area tail at positions 1366..1374 are both reached. With four as the limit, a five-entry list is short enough to exercise the overflow failure. Failures in the middle of a list, the two position-0 cases and stalled producers are each checked against the reference model's memory image and its busy-cycle timeline.

// File: rtl/rsbm_pkg.sv
package rsbm_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = SYM_W - BYTE_W;
  localparam int PAD_W  = 2 * BYTE_W - SYM_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_B0,
    S_B1,
    S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    R_IDLE,
    R_RD,
    R_WR
  } rmw_state_t;
endpackage

// File: rtl/rsbm_symbol_map.sv
module rsbm_symbol_map #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int LAST_POS    = 1374,
  parameter int POS_W       = 11,
  parameter int ADDR_W      = 11
) (
  input  logic [POS_W-1:0]             pos,
  input  logic [rsbm_pkg::SYM_W-1:0]   pat,
  output logic                         bad,
  output logic                         v0,
  output logic                         s0,
  output logic [ADDR_W-1:0]            a0,
  output logic [rsbm_pkg::BYTE_W-1:0]  m0,
  output logic                         s1,
  output logic [ADDR_W-1:0]            a1,
  output logic [rsbm_pkg::BYTE_W-1:0]  m1
);
  import rsbm_pkg::*;

  localparam int LIN_W = POS_W + 2;
  localparam int TOTAL = DATA_BYTES + SPARE_BYTES;
  localparam logic [POS_W-1:0] LAST_P  = POS_W'(LAST_POS);
  localparam logic [LIN_W-1:0] DATA_L  = LIN_W'(DATA_BYTES);
  localparam logic [LIN_W-1:0] TOTAL_L = LIN_W'(TOTAL);
  localparam logic [LIN_W-1:0] ONE_L   = LIN_W'(1);

  logic [LIN_W-1:0] triple, lin, lo_idx, hi_idx, lo_off, hi_off;
  logic odd, at_zero;

  always_comb begin
    triple  = {2'b00, pos} + {1'b0, pos, 1'b0};
    lin     = triple >> 1;
    odd     = pos[0];
    at_zero = (pos == '0);
    lo_idx  = odd ? lin : lin - ONE_L;
    hi_idx  = odd ? lin + ONE_L : lin;

    if (odd) begin
      m0 = pat[SYM_W-1:NIB_W];
      m1 = {pat[NIB_W-1:0], {NIB_W{1'b0}}};
    end else begin
      m0 = {{PAD_W{1'b0}}, pat[SYM_W-1:BYTE_W]};
      m1 = pat[BYTE_W-1:0];
    end

    v0     = !at_zero;
    s0     = (lo_idx >= DATA_L);
    s1     = (hi_idx >= DATA_L);
    lo_off = s0 ? lo_idx - DATA_L : lo_idx;
    hi_off = s1 ? hi_idx - DATA_L : hi_idx;
    a0     = lo_off[ADDR_W-1:0];
    a1     = hi_off[ADDR_W-1:0];

    bad = (pos > LAST_P)
        || (at_zero && (pat[SYM_W-1:BYTE_W] != '0))
        || (hi_idx >= TOTAL_L);
  end
endmodule

// File: rtl/rsbm_rmw.sv
module rsbm_rmw #(
  parameter int ADDR_W = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         op_spare,
  input  logic [ADDR_W-1:0]            op_addr,
  input  logic [rsbm_pkg::BYTE_W-1:0]  op_mask,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic                         mem_spare,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [rsbm_pkg::BYTE_W-1:0]  mem_wdata,
  input  logic [rsbm_pkg::BYTE_W-1:0]  mem_rdata,
  output logic                         fin
);
  import rsbm_pkg::*;

  rmw_state_t st;
  logic [BYTE_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= R_IDLE;
      mask_q    <= '0;
      mem_spare <= 1'b0;
      mem_addr  <= '0;
    end else if (start) begin
      st        <= R_RD;
      mask_q    <= op_mask;
      mem_spare <= op_spare;
      mem_addr  <= op_addr;
    end else begin
      case (st)
        R_RD:    st <= R_WR;
        default: st <= R_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (st == R_RD);
    mem_wr    = (st == R_WR);
    fin       = (st == R_WR);
    mem_wdata = mem_wr ? (mem_rdata ^ mask_q) : '0;
  end
endmodule

// File: rtl/rsbm_seq.sv
module rsbm_seq #(
  parameter int POS_W   = 11,
  parameter int ADDR_W  = 11,
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [POS_W-1:0]             in_pos,
  input  logic [rsbm_pkg::SYM_W-1:0]   in_pat,
  input  logic                         in_last,
  output logic [POS_W-1:0]             ent_pos,
  output logic [rsbm_pkg::SYM_W-1:0]   ent_pat,
  input  logic                         map_bad,
  input  logic                         map_v0,
  input  logic                         map_s0,
  input  logic [ADDR_W-1:0]            map_a0,
  input  logic [rsbm_pkg::BYTE_W-1:0]  map_m0,
  input  logic                         map_s1,
  input  logic [ADDR_W-1:0]            map_a1,
  input  logic [rsbm_pkg::BYTE_W-1:0]  map_m1,
  input  logic                         rmw_fin,
  output logic                         op_start,
  output logic                         op_spare,
  output logic [ADDR_W-1:0]            op_addr,
  output logic [rsbm_pkg::BYTE_W-1:0]  op_mask,
  output logic                         done,
  output logic                         done_fail,
  output logic [CNT_W-1:0]             done_count
);
  import rsbm_pkg::*;

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ERR);

  seq_state_t st;
  logic last_q, fail_q, skip, use_hi;
  logic [CNT_W-1:0] cnt_q;

  assign skip = map_bad || fail_q || (cnt_q == MAX_C);

  always_comb begin
    in_ready = (st == S_IDLE);
    op_start = 1'b0;
    use_hi   = 1'b1;
    case (st)
      S_CHK: if (!skip) begin
        op_start = 1'b1;
        use_hi   = !map_v0;
      end
      S_B0: if (rmw_fin) op_start = 1'b1;
      default: ;
    endcase
    op_spare = use_hi ? map_s1 : map_s0;
    op_addr  = use_hi ? map_a1 : map_a0;
    op_mask  = use_hi ? map_m1 : map_m0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ent_pos <= '0;
      ent_pat <= '0;
      last_q  <= 1'b0;
      fail_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          ent_pos <= in_pos;
          ent_pat <= in_pat;
          last_q  <= in_last;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (skip) begin
            fail_q <= 1'b1;
            st     <= last_q ? S_DONE : S_IDLE;
          end else begin
            st <= map_v0 ? S_B0 : S_B1;
          end
        end
        S_B0: if (rmw_fin) st <= S_B1;
        S_B1: if (rmw_fin) begin
          cnt_q <= cnt_q + CNT_W'(1);
          st    <= last_q ? S_DONE : S_IDLE;
        end
        S_DONE: begin
          fail_q <= 1'b0;
          cnt_q  <= '0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    done       = (st == S_DONE);
    done_fail  = done && fail_q;
    done_count = (done && !fail_q) ? cnt_q : '0;
  end
endmodule

// File: rtl/rs_byte_fixer.sv
module rs_byte_fixer #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_ERR     = 4,
  parameter int LAST_POS    = 1374,
  parameter int POS_W       = 11,
  localparam int ADDR_W     = $clog2(DATA_BYTES),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [POS_W-1:0]             in_pos,
  input  logic [rsbm_pkg::SYM_W-1:0]   in_pat,
  input  logic                         in_last,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic                         mem_spare,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [rsbm_pkg::BYTE_W-1:0]  mem_wdata,
  input  logic [rsbm_pkg::BYTE_W-1:0]  mem_rdata,
  output logic                         done,
  output logic                         done_fail,
  output logic [CNT_W-1:0]             done_count
);
  import rsbm_pkg::*;

  logic [POS_W-1:0]  ent_pos;
  logic [SYM_W-1:0]  ent_pat;
  logic              map_bad, map_v0, map_s0, map_s1;
  logic [ADDR_W-1:0] map_a0, map_a1, op_addr;
  logic [BYTE_W-1:0] map_m0, map_m1, op_mask;
  logic              op_start, op_spare, rmw_fin;

  rsbm_symbol_map #(
    .DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .LAST_POS(LAST_POS), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_map (
    .pos(ent_pos), .pat(ent_pat), .bad(map_bad), .v0(map_v0),
    .s0(map_s0), .a0(map_a0), .m0(map_m0),
    .s1(map_s1), .a1(map_a1), .m1(map_m1)
  );

  rsbm_seq #(
    .POS_W(POS_W), .ADDR_W(ADDR_W), .MAX_ERR(MAX_ERR), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_pos(in_pos), .in_pat(in_pat), .in_last(in_last),
    .ent_pos(ent_pos), .ent_pat(ent_pat),
    .map_bad(map_bad), .map_v0(map_v0),
    .map_s0(map_s0), .map_a0(map_a0), .map_m0(map_m0),
    .map_s1(map_s1), .map_a1(map_a1), .map_m1(map_m1),
    .rmw_fin(rmw_fin), .op_start(op_start), .op_spare(op_spare),
    .op_addr(op_addr), .op_mask(op_mask),
    .done(done), .done_fail(done_fail), .done_count(done_count)
  );

  rsbm_rmw #(.ADDR_W(ADDR_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .start(op_start),
    .op_spare(op_spare), .op_addr(op_addr), .op_mask(op_mask),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_spare(mem_spare),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fin(rmw_fin)
  );
endmodule

// File: rtl/rs_byte_fixer_chk.sv
module rs_byte_fixer_chk #(
  parameter int ADDR_W  = 11,
  parameter int CNT_W   = 3,
  parameter int MAX_ERR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_spare,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              done_fail,
  input logic [CNT_W-1:0]  done_count
);
  // R9: a read is followed by the write to the same byte
  p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && $stable(mem_addr) && $stable(mem_spare)));

  // R9: every write is preceded by its read
  p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  // R9: producer is stalled while the byte port is busy
  p_ready_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !in_ready);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: status is quiet outside the pulse
  p_status_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!done_fail && done_count == '0));

  // R7: a failed page reports zero corrections
  p_fail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> (done_count == '0));

  // R6: never more corrections than the limit
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(done_count) <= MAX_ERR));
endmodule

bind rs_byte_fixer rs_byte_fixer_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_ERR(MAX_ERR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_spare(mem_spare),
  .mem_addr(mem_addr), .done(done), .done_fail(done_fail),
  .done_count(done_count)
);

// File: tb/rs_byte_fixer_tb.sv
module rs_byte_fixer_tb;
  localparam int DATA_BYTES  = 2048;
  localparam int SPARE_BYTES = 64;
  localparam int MAX_ERR     = 4;
  localparam int LAST_POS    = 1374;
  localparam int POS_W       = 11;
  localparam int ADDR_W      = $clog2(DATA_BYTES);
  localparam int CNT_W       = $clog2(MAX_ERR + 1);
  localparam int SPLIT       = (2 * DATA_BYTES) / 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [POS_W-1:0] in_pos = '0;
  logic [11:0] in_pat = '0;
  logic in_ready, mem_rd, mem_wr, mem_spare, done, done_fail;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [CNT_W-1:0] done_count;

  always #10 clk = ~clk;

  rs_byte_fixer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pos(in_pos), .in_pat(in_pat), .in_last(in_last),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_spare(mem_spare),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .done_fail(done_fail), .done_count(done_count)
  );

  function automatic logic [7:0] init_d(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction
  function automatic logic [7:0] init_s(int i);
    return 8'((i * 91 + 200) ^ (i << 2));
  endfunction

  // Bench-side byte memories, one-cycle read latency
  logic [7:0] dmem [DATA_BYTES];
  logic [7:0] smem [SPARE_BYTES];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) dmem[i] <= init_d(i);
      for (int i = 0; i < SPARE_BYTES; i++) smem[i] <= init_s(i);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_rd) mem_rdata <= mem_spare ? smem[mem_addr] : dmem[mem_addr];
      if (mem_wr) begin
        if (mem_spare) smem[mem_addr] <= mem_wdata;
        else dmem[mem_addr] <= mem_wdata;
      end
    end
  end

  // Reference model state
  logic [7:0] exp_d [DATA_BYTES];
  logic [7:0] exp_s [SPARE_BYTES];
  int checks = 0, errors = 0;
  int busy_left = 0;
  bit pend_last = 0, mfail = 0, exp_fail = 0;
  int mcnt = 0, exp_cnt = 0;
  int lp[8], lt[8], lg[8];
  int ln = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  // Spec-level byte updates (separate data / spare rules, not unified)
  task automatic apply(input int p, input int t);
    int b;
    b = (3 * p) / 2;
    if (p == 0) exp_d[0] ^= 8'(t);
    else if (p == SPLIT) begin
      exp_d[DATA_BYTES-1] ^= 8'(t >> 4);
      exp_s[0] ^= 8'(t << 4);
    end else if (p > SPLIT) begin
      if (p % 2 == 1) begin
        exp_s[b - DATA_BYTES]     ^= 8'(t >> 4);
        exp_s[b - DATA_BYTES + 1] ^= 8'(t << 4);
      end else begin
        exp_s[b - DATA_BYTES - 1] ^= 8'(t >> 8);
        exp_s[b - DATA_BYTES]     ^= 8'(t);
      end
    end else if (p % 2 == 1) begin
      exp_d[b]     ^= 8'(t >> 4);
      exp_d[b + 1] ^= 8'(t << 4);
    end else begin
      exp_d[b - 1] ^= 8'(t >> 8);
      exp_d[b]     ^= 8'(t);
    end
  endtask

  task automatic model_accept(input int p, input int t, input bit last);
    bit f;
    int nb;
    f = mfail || (mcnt >= MAX_ERR) || (p > LAST_POS) || (p == 0 && t > 255);
    nb = 0;
    if (f) mfail = 1;
    else begin
      apply(p, t);
      mcnt++;
      nb = (p == 0) ? 1 : 2;
    end
    busy_left = 1 + 2 * nb + (last ? 1 : 0);
    pend_last = last;
    if (last) begin
      exp_fail = mfail;
      exp_cnt  = mfail ? 0 : mcnt;
      mfail = 0;
      mcnt  = 0;
    end
  endtask

  // One clock: advance to the falling edge and compare with the model
  task automatic cycle();
    bit exp_done;
    @(negedge clk);
    chk(in_ready == (busy_left == 0), "R9", "in_ready", in_ready, busy_left == 0);
    exp_done = pend_last && (busy_left == 1);
    chk(done == exp_done, "R8", "done", done, exp_done);
    if (exp_done) begin
      chk(done_fail == exp_fail, "R7", "done_fail", done_fail, exp_fail);
      chk(int'(done_count) == exp_cnt, "R8", "done_count", done_count, exp_cnt);
    end
    if (busy_left == 0)
      chk(!mem_rd && !mem_wr, "R9", "idle port", {mem_rd, mem_wr}, 0);
    if (busy_left > 0) busy_left--;
  endtask

  task automatic add(input int p, input int t, input int g);
    lp[ln] = p; lt[ln] = t; lg[ln] = g; ln++;
  endtask

  task automatic cmp_mem(input string tag);
    int bad, first, got, want;
    bad = 0; first = -1; got = 0; want = 0;
    for (int i = 0; i < DATA_BYTES; i++)
      if (dmem[i] !== exp_d[i]) begin
        if (first < 0) begin first = i; got = dmem[i]; want = exp_d[i]; end
        bad++;
      end
    for (int i = 0; i < SPARE_BYTES; i++)
      if (smem[i] !== exp_s[i]) begin
        if (first < 0) begin first = DATA_BYTES + i; got = smem[i]; want = exp_s[i]; end
        bad++;
      end
    chk(bad == 0, tag, $sformatf("memory image (first byte %0d)", first), got, want);
  endtask

  task automatic run(input string tag);
    bit acc;
    for (int i = 0; i < ln; i++) begin
      for (int g = 0; g < lg[i]; g++) begin
        in_valid = 1'b0;
        cycle();
      end
      in_valid = 1'b1;
      in_pos   = POS_W'(lp[i]);
      in_pat   = 12'(lt[i]);
      in_last  = (i == ln - 1);
      forever begin
        acc = in_ready;
        if (acc) model_accept(lp[i], lt[i], i == ln - 1);
        cycle();
        if (acc) break;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (busy_left > 0) cycle();
    cycle();
    cmp_mem(tag);
    ln = 0;
  endtask

  initial begin
    for (int i = 0; i < DATA_BYTES; i++) exp_d[i] = init_d(i);
    for (int i = 0; i < SPARE_BYTES; i++) exp_s[i] = init_s(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cycle();
    // R10: reset state
    chk(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);
    chk(done == 1'b0, "R10", "done", done, 0);
    chk(!mem_rd && !mem_wr, "R10", "port strobes", {mem_rd, mem_wr}, 0);

    add(1, 'hABC, 0);                          run("R1");
    add(999, 'h5E7, 2); add(1363, 'hFFF, 0);   run("R1");
    add(2, 'h3C5, 0); add(10, 'h0F0, 1);       run("R2");
    add(1364, 'h801, 0);                       run("R2");
    add(0, 'h5A, 0);                           run("R3");
    add(0, 'h1A5, 0);                          run("R3");
    add(SPLIT, 'hFED, 0); add(1366, 'h123, 0); add(LAST_POS, 'h9A7, 3); run("R4");
    add(1369, 'h4B2, 0);                       run("R4");
    add(LAST_POS + 1, 'h111, 0);               run("R5");
    add(2000, 'h222, 1);                       run("R5");
    add(3, 'h101, 0); add(4, 'h202, 0); add(5, 'h303, 0); add(6, 'h404, 0);
    add(7, 'h505, 0);                          run("R6");
    add(5, 'h111, 0); add(1400, 'h001, 2); add(7, 'h222, 0); run("R7");
    add(0, 'hF00, 0); add(20, 'h777, 0);       run("R7");
    add(100, 'h321, 3); add(101, 'h654, 0); add(0, 'h0FF, 5); add(1370, 'hA5A, 1);
    run("R8");
    add(50, 'hCCC, 0);                         run("R9");
    summary();
  end
endmodule